// File: doc/BRIEF.md
# Compact ISA Program Counter Unit

This block holds the program counter of a processor whose instructions are all one 16-bit word, and picks the next counter value from the instruction being executed. It covers four kinds of flow. Sequential flow steps by one. An absolute jump or call replaces the low 14 bits of the counter and keeps the segment bits above them. A conditional branch tests a register for zero and moves the counter by a signed 6-bit distance. A return loads the counter from the address held in the current activation record.

The block does not touch the register window itself. On a call it raises a strobe with the address to save and the frame size. On a return it raises a strobe with the frame size from the instruction. For a return that carries a value, it also names the register to be copied into global r0. The branch-test register index is decoded here and sent out, and its contents come back on `test_val_i`. The frame size of a call is supplied by the decode side on `call_size_i`, because the call word has no room for it.

Top module: `pcu_top`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0x0000 and every strobe is low.
- R2: An instruction that does not belong to a flow-change class advances the counter by one, wrapping modulo 2^16. This covers top bits 00, and top bits 11 with any op code other than 0x10 to 0x13. When `instr_valid_i` is low, the counter holds and all strobes stay low.
- R3: Jump (top bits 01) sets the next PC to {pc[15:14], instr[13:0]}.
- R4: Call (top bits 10) gives the same target as a jump. It raises `call_o` for that cycle, with `call_ret_addr_o` = pc+1 and `call_size_o` = `call_size_i`.
- R5: Branch-if-true uses top bits 11 and op code instr[13:9] = 0x10. If `test_val_i` is non-zero, the next PC is pc + 1 + sign_extend(instr[5:0]); otherwise it is pc+1. `test_reg_o` always shows instr[8:6].
- R6: Branch-if-false (op code 0x11) takes the same displacement when `test_val_i` is zero, and otherwise falls through to pc+1.
- R7: Return (op code 0x12) sets the next PC to `ret_addr_i`. It raises `ret_o`, and `ret_size_o` = instr[3:0].
- R8: Return-with-value (op code 0x13) acts as a return. It also raises `rv_copy_o`, with `rv_reg_o` = instr[8:6].
- R9: At most one of `call_o` and `ret_o` is high in any cycle. `rv_copy_o` is high only together with `ret_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction on `instr_i` executes this cycle |
| instr_i | input | 16 | Current instruction word |
| test_val_i | input | 16 | Contents of the register named by `test_reg_o` |
| ret_addr_i | input | 16 | Return address read from the activation record |
| call_size_i | input | 4 | Frame size for a call, from decode |
| pc_o | output | 16 | Current program counter |
| next_pc_o | output | 16 | Counter value after this instruction |
| test_reg_o | output | 3 | Index of the register under test |
| call_o | output | 1 | Call strobe |
| call_ret_addr_o | output | 16 | Address to store in the new record |
| call_size_o | output | 4 | Frame size of the call |
| ret_o | output | 1 | Return strobe |
| ret_size_o | output | 4 | Frame size released by the return |
| rv_copy_o | output | 1 | Copy `rv_reg_o` into r0 |
| rv_reg_o | output | 3 | Register holding the return value |

## Verification
The assertions assume that `instr_i`, `test_val_i`, `ret_addr_i` and `call_size_i` are stable and known whenever `instr_valid_i` is high, and that the read-back return address is already present in the cycle of the return. The bench changes inputs only on the falling edge. It draws every input from a fixed-seed generator, weighted so that each instruction class, both branch outcomes, the extreme displacements and all four segments appear. Directed cases add counter wrap at 0xFFFF and stalled cycles.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned ABS_W   = 14;
  localparam int unsigned DISP_W  = 6;
  localparam int unsigned REG_W   = 3;
  localparam int unsigned OP_W    = 5;

  localparam logic [1:0] FMT_JMP  = 2'b01;
  localparam logic [1:0] FMT_CALL = 2'b10;
  localparam logic [1:0] FMT_EXT  = 2'b11;

  localparam logic [OP_W-1:0] OP_BT   = 5'h10;
  localparam logic [OP_W-1:0] OP_BF   = 5'h11;
  localparam logic [OP_W-1:0] OP_RET  = 5'h12;
  localparam logic [OP_W-1:0] OP_RETV = 5'h13;

  typedef enum logic [2:0] {
    K_SEQ, K_JMP, K_CALL, K_BT, K_BF, K_RET, K_RETV
  } kind_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int unsigned FRAME_W = 4
) (
  input  logic [INSTR_W-1:0] instr_i,
  output kind_e              kind_o,
  output logic [ABS_W-1:0]   abs_o,
  output logic [DISP_W-1:0]  disp_o,
  output logic [REG_W-1:0]   reg_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [1:0]      fmt;
  logic [OP_W-1:0] op;

  assign fmt     = instr_i[INSTR_W-1 -: 2];
  assign op      = instr_i[INSTR_W-3 -: OP_W];
  assign abs_o   = instr_i[ABS_W-1:0];
  assign disp_o  = instr_i[DISP_W-1:0];
  assign reg_o   = instr_i[DISP_W +: REG_W];
  assign frame_o = instr_i[FRAME_W-1:0];

  always_comb begin
    kind_o = K_SEQ;
    unique case (fmt)
      FMT_JMP:  kind_o = K_JMP;
      FMT_CALL: kind_o = K_CALL;
      FMT_EXT: begin
        unique case (op)
          OP_BT:   kind_o = K_BT;
          OP_BF:   kind_o = K_BF;
          OP_RET:  kind_o = K_RET;
          OP_RETV: kind_o = K_RETV;
          default: kind_o = K_SEQ;
        endcase
      end
      default:  kind_o = K_SEQ;
    endcase
  end
endmodule

// File: rtl/pcu_cond.sv
module pcu_cond
  import pcu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  kind_e              kind_i,
  input  logic [DATA_W-1:0]  test_val_i,
  output logic               taken_o
);
  logic nonzero;
  assign nonzero = |test_val_i;

  always_comb begin
    unique case (kind_i)
      K_BT:    taken_o = nonzero;
      K_BF:    taken_o = !nonzero;
      default: taken_o = 1'b0;
    endcase
  end

  // p_taken_branch_r5: only a branch can be taken
  always_comb begin
    p_taken_branch_r5: assert (!taken_o || kind_i == K_BT || kind_i == K_BF);
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  kind_e             kind_i,
  input  logic [ABS_W-1:0]  abs_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              taken_i,
  input  logic [PC_W-1:0]   ret_addr_i,
  output logic [PC_W-1:0]   seq_pc_o,
  output logic [PC_W-1:0]   next_pc_o
);
  localparam int unsigned SEG_W = PC_W - ABS_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] abs_pc;
  logic [PC_W-1:0] rel_pc;

  assign seq_pc_o = pc_i + PC_W'(1);
  assign disp_ext = {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign rel_pc   = seq_pc_o + disp_ext;

  generate
    if (SEG_W > 0) begin : g_seg
      assign abs_pc = {pc_i[PC_W-1 -: SEG_W], abs_i};
    end else begin : g_flat
      assign abs_pc = pc_i;
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      K_JMP, K_CALL: next_pc_o = abs_pc;
      K_RET, K_RETV: next_pc_o = ret_addr_i;
      K_BT, K_BF:    next_pc_o = taken_i ? rel_pc : seq_pc_o;
      default:       next_pc_o = seq_pc_o;
    endcase
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W    = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  test_val_i,
  input  logic [PC_W-1:0]    ret_addr_i,
  input  logic [FRAME_W-1:0] call_size_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [REG_W-1:0]   test_reg_o,
  output logic               call_o,
  output logic [PC_W-1:0]    call_ret_addr_o,
  output logic [FRAME_W-1:0] call_size_o,
  output logic               ret_o,
  output logic [FRAME_W-1:0] ret_size_o,
  output logic               rv_copy_o,
  output logic [REG_W-1:0]   rv_reg_o
);
  kind_e              kind;
  logic [ABS_W-1:0]   abs_f;
  logic [DISP_W-1:0]  disp_f;
  logic [REG_W-1:0]   reg_f;
  logic [FRAME_W-1:0] frame_f;
  logic               taken;
  logic [PC_W-1:0]    seq_pc;
  logic [PC_W-1:0]    tgt_pc;
  logic [PC_W-1:0]    pc_q;

  pcu_decode #(.FRAME_W(FRAME_W)) u_dec (
    .instr_i (instr_i),
    .kind_o  (kind),
    .abs_o   (abs_f),
    .disp_o  (disp_f),
    .reg_o   (reg_f),
    .frame_o (frame_f)
  );

  pcu_cond #(.DATA_W(DATA_W)) u_cond (
    .kind_i     (kind),
    .test_val_i (test_val_i),
    .taken_o    (taken)
  );

  pcu_target #(.PC_W(PC_W)) u_tgt (
    .pc_i       (pc_q),
    .kind_i     (kind),
    .abs_i      (abs_f),
    .disp_i     (disp_f),
    .taken_i    (taken),
    .ret_addr_i (ret_addr_i),
    .seq_pc_o   (seq_pc),
    .next_pc_o  (tgt_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pc_q <= '0;
    else if (instr_valid_i) pc_q <= tgt_pc;
  end

  logic is_ret;
  assign is_ret = (kind == K_RET) || (kind == K_RETV);

  assign pc_o            = pc_q;
  assign next_pc_o       = instr_valid_i ? tgt_pc : pc_q;
  assign test_reg_o      = reg_f;
  assign call_o          = rst_ni && instr_valid_i && (kind == K_CALL);
  assign call_ret_addr_o = seq_pc;
  assign call_size_o     = call_size_i;
  assign ret_o           = rst_ni && instr_valid_i && is_ret;
  assign ret_size_o      = frame_f;
  assign rv_copy_o       = rst_ni && instr_valid_i && (kind == K_RETV);
  assign rv_reg_o        = reg_f;

  // assertions
  p_reset_pc_r1: assert property (@(posedge clk_i)
    !rst_ni |=> pc_o == '0 || rst_ni);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(pc_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[INSTR_W-1 -: 2] == 2'b00 |=> pc_o == $past(pc_o) + PC_W'(1));

  p_seg_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |=> pc_o[PC_W-1 -: (PC_W-ABS_W)] == $past(pc_o[PC_W-1 -: (PC_W-ABS_W)]));

  p_ret_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |=> pc_o == $past(ret_addr_i));

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({call_o, ret_o}));

  p_rv_ret_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_copy_o |-> ret_o);
endmodule

// File: tb/pcu_top_tb_top.sv
module pcu_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] test_val_i = '0;
  logic [15:0] ret_addr_i = '0;
  logic [3:0]  call_size_i = '0;
  logic [15:0] pc_o, next_pc_o, call_ret_addr_o;
  logic [2:0]  test_reg_o, rv_reg_o;
  logic        call_o, ret_o, rv_copy_o;
  logic [3:0]  call_size_o, ret_size_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model_pc = '0;

  always #2 clk_i = ~clk_i;

  pcu_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i),
    .instr_i(instr_i), .test_val_i(test_val_i), .ret_addr_i(ret_addr_i),
    .call_size_i(call_size_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .test_reg_o(test_reg_o), .call_o(call_o), .call_ret_addr_o(call_ret_addr_o),
    .call_size_o(call_size_o), .ret_o(ret_o), .ret_size_o(ret_size_o),
    .rv_copy_o(rv_copy_o), .rv_reg_o(rv_reg_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // class: 0 seq,1 jmp,2 call,3 bt,4 bf,5 ret,6 retv
  function automatic int cls(input logic [15:0] ins);
    if (ins[15:14] == 2'b01) return 1;
    if (ins[15:14] == 2'b10) return 2;
    if (ins[15:14] == 2'b11) begin
      case (ins[13:9])
        5'h10: return 3;
        5'h11: return 4;
        5'h12: return 5;
        5'h13: return 6;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] pc, input logic [15:0] ins,
                                           input logic [15:0] tv, input logic [15:0] ra);
    logic [15:0] rel;
    rel = pc + 16'd1 + {{10{ins[5]}}, ins[5:0]};
    case (cls(ins))
      1, 2: return {pc[15:14], ins[13:0]};
      3: return (tv != 0) ? rel : pc + 16'd1;
      4: return (tv == 0) ? rel : pc + 16'd1;
      5, 6: return ra;
      default: return pc + 16'd1;
    endcase
  endfunction

  // apply one instruction at negedge, check outputs, commit at posedge
  task automatic step(input bit v, input logic [15:0] ins, input logic [15:0] tv,
                      input logic [15:0] ra, input logic [3:0] cs);
    int c;
    logic [15:0] nx;
    @(negedge clk_i);
    instr_valid_i = v; instr_i = ins; test_val_i = tv; ret_addr_i = ra; call_size_i = cs;
    #1;
    c = cls(ins);
    nx = v ? exp_next(model_pc, ins, tv, ra) : model_pc;
    case (c)
      1: chk("R3 jump next", next_pc_o, nx);
      2: chk("R4 call next", next_pc_o, nx);
      3: chk("R5 bt next", next_pc_o, nx);
      4: chk("R6 bf next", next_pc_o, nx);
      5: chk("R7 ret next", next_pc_o, nx);
      6: chk("R8 retv next", next_pc_o, nx);
      default: chk("R2 seq next", next_pc_o, nx);
    endcase
    chk("R5 test_reg", {13'd0, test_reg_o}, {13'd0, ins[8:6]});
    chk("R4 call strobe", {15'd0, call_o}, {15'd0, v && c == 2});
    if (v && c == 2) begin
      chk("R4 call ret addr", call_ret_addr_o, model_pc + 16'd1);
      chk("R4 call size", {12'd0, call_size_o}, {12'd0, cs});
    end
    chk("R7 ret strobe", {15'd0, ret_o}, {15'd0, v && (c == 5 || c == 6)});
    if (v && (c == 5 || c == 6))
      chk("R7 ret size", {12'd0, ret_size_o}, {12'd0, ins[3:0]});
    chk("R8 rv strobe", {15'd0, rv_copy_o}, {15'd0, v && c == 6});
    if (v && c == 6) chk("R8 rv reg", {13'd0, rv_reg_o}, {13'd0, ins[8:6]});
    chk("R9 exclusive", {15'd0, call_o & ret_o}, 16'd0);
    @(posedge clk_i);
    model_pc = nx;
    #1;
    if (v) chk("R2 pc commit", pc_o, model_pc);
    else   chk("R2 hold", pc_o, model_pc);
  endtask

  function automatic logic [15:0] ext(input logic [4:0] op, input logic [2:0] r,
                                      input logic [5:0] d);
    return {2'b11, op, r, d};
  endfunction

  initial begin
    #30000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #7;
    chk("R1 reset pc", pc_o, 16'h0000);
    chk("R1 reset strobes", {13'd0, call_o, ret_o, rv_copy_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // directed corner cases
    step(1, 16'h1234, 0, 0, 0);                       // R2 seq from 0
    step(1, ext(5'h10, 3'd2, 6'h3f), 16'h0001, 0, 0); // R5 taken -1
    step(1, ext(5'h10, 3'd2, 6'h05), 16'h0000, 0, 0); // R5 not taken
    step(1, ext(5'h11, 3'd1, 6'h20), 16'h0000, 0, 0); // R6 taken -32 wraps
    step(1, ext(5'h11, 3'd1, 6'h1f), 16'h8000, 0, 0); // R6 not taken
    step(1, ext(5'h12, 3'd0, 6'h08), 0, 16'hffff, 0); // R7 to ffff
    step(1, 16'h0000, 0, 0, 0);                       // R2 wrap to 0
    step(1, 16'hc000, 0, 0, 0);                       // ext unknown op: R2
    step(1, ext(5'h13, 3'd5, 6'h03), 0, 16'hc123, 0); // R8 into segment 3
    step(1, 16'h7abc, 0, 0, 0);                       // R3 keeps segment 3
    step(1, 16'ha001, 0, 0, 4'd8);                    // R4 call in segment 3
    step(0, ext(5'h12, 3'd0, 6'h02), 0, 16'h5555, 0); // R2 stalled return
    step(1, ext(5'h10, 3'd7, 6'h1f), 16'h0100, 0, 0); // R5 +31
    // random
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [15:0] ins;
      logic [15:0] tv;
      k = int'($urandom_range(0, 7));
      ins = 16'($urandom);
      case (k)
        1: ins[15:14] = 2'b01;
        2: ins[15:14] = 2'b10;
        3: ins = ext(5'h10, ins[8:6], ins[5:0]);
        4: ins = ext(5'h11, ins[8:6], ins[5:0]);
        5: ins = ext(5'h12, ins[8:6], ins[5:0]);
        6: ins = ext(5'h13, ins[8:6], ins[5:0]);
        default: ;
      endcase
      tv = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom);
      step($urandom_range(0, 9) != 0, ins, tv, 16'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule